// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Causes

A 32-pin general-purpose I/O bank driven through a simple word-addressed register port with separate read and write strobes. Per pin it holds an output value, a direction bit, a blink enable, a blink counter select and an input polarity bit. A read-only data-in register reports the synchronised pin level after polarity inversion.

The interrupt path works on the polarity-adjusted input. A low-to-high change of that input sets a sticky edge cause bit, so falling edges are caught by setting the polarity bit. Software clears cause bits by writing zeros to them. A level cause is taken straight from the adjusted input. Each cause kind has its own mask. The masked causes are merged and OR-reduced per group of eight consecutive pins onto four summary interrupt lines.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every register reads zero. Every pin is an output (`pin_oe_o` all ones) driving zero, and `irq_o` is zero.
- R2: The writable registers sit at byte offsets 0x00 output, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x18 edge mask, 0x1C level mask and 0x20 blink select. Each reads back the last value written.
- R3: A direction bit of 1 makes its pin an input (`pin_oe_o` bit 0). A direction bit of 0 enables the driver. `pin_o` carries the output register.
- R4: Data-in at offset 0x10 reads `pin_i` XOR polarity. A pin change becomes visible two clock edges after it is applied. Writes to 0x10 have no effect.
- R5: A rise of the polarity-adjusted input sets its edge cause bit (offset 0x14) one edge after data-in changes. A fall sets nothing, so a falling pin edge is caught only with polarity set.
- R6: A write to the edge cause register clears each bit written 0 and keeps each bit written 1.
- R7: If a new edge and a clearing write reach the same cause bit in the same cycle, the bit ends up set.
- R8: A level cause equals data-in AND level mask. It stays asserted as long as the pin holds that level, and writes to the edge cause register do not affect it.
- R9: Edge cause bits latch regardless of the edge mask. They reach an interrupt only where the edge mask bit is 1.
- R10: `irq_o[g]` is the OR of the combined masked cause over pins 8g to 8g+7, and of no other pins.
- R11: Reads of offsets not listed in R2, R4 or R5 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, combinational, zero when not reading |
| pin_i | input | 32 | Pin levels from the pads |
| pin_o | output | 32 | Output values to the pads |
| pin_oe_o | output | 32 | Pad driver enables, 1 = drive |
| blink_en_o | output | 32 | Per-pin blink enable to the blink generator |
| blink_sel_o | output | 32 | Per-pin blink counter select |
| irq_o | output | 4 | Summary interrupts, one per group of eight pins |

## Verification
A stale or corrupted edge cause bit is visible at the ports. It appears as a summary line asserted for the wrong group of eight pins one edge after the fault, and it persists in the cause register on the next read, because cause bits only clear by software write. A wrong previous-sample register shows up as a missing or a spurious cause exactly one edge after the data-in change. The bench checks this by sampling cause and `irq_o` at fixed cycle counts after each pin change. A wrong synchroniser depth shifts data-in visibility by a cycle, and the bench catches it by sampling after the first and second edges.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_OUT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_BLINK = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_POL   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_DIN   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_EMASK = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_LMASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_BSEL  = 8'h20;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rd_data_o,
  input  logic [W-1:0]      din_i,
  input  logic [W-1:0]      cause_i,
  output logic              cause_wr_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      blink_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      emask_o,
  output logic [W-1:0]      lmask_o,
  output logic [W-1:0]      bsel_o
);
  logic [W-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q, bsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
      bsel_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_OUT:   out_q   <= wdata_i;
        OFF_DIR:   dir_q   <= wdata_i;
        OFF_BLINK: blink_q <= wdata_i;
        OFF_POL:   pol_q   <= wdata_i;
        OFF_EMASK: emask_q <= wdata_i;
        OFF_LMASK: lmask_q <= wdata_i;
        OFF_BSEL:  bsel_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        OFF_OUT:   rd_data_o = out_q;
        OFF_DIR:   rd_data_o = dir_q;
        OFF_BLINK: rd_data_o = blink_q;
        OFF_POL:   rd_data_o = pol_q;
        OFF_DIN:   rd_data_o = din_i;
        OFF_CAUSE: rd_data_o = cause_i;
        OFF_EMASK: rd_data_o = emask_q;
        OFF_LMASK: rd_data_o = lmask_q;
        OFF_BSEL:  rd_data_o = bsel_q;
        default:   rd_data_o = '0;
      endcase
    end
  end

  assign cause_wr_o = wr_en_i && (addr_i == OFF_CAUSE);
  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign blink_o = blink_q;
  assign pol_o   = pol_q;
  assign emask_o = emask_q;
  assign lmask_o = lmask_q;
  assign bsel_o  = bsel_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W     = 32,
  parameter int unsigned GROUP = 8,
  localparam int unsigned N_GRP = W / GROUP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     din_i,
  input  logic             clr_en_i,
  input  logic [W-1:0]     clr_data_i,
  input  logic [W-1:0]     emask_i,
  input  logic [W-1:0]     lmask_i,
  output logic [W-1:0]     cause_o,
  output logic [W-1:0]     rise_o,
  output logic [N_GRP-1:0] irq_o
);
  logic [W-1:0] prev_q, cause_q, cause_d, combined;

  assign rise_o = din_i & ~prev_q;

  // new edge beats a same-cycle clear
  always_comb begin
    cause_d = cause_q;
    if (clr_en_i) cause_d = cause_q & clr_data_i;
    cause_d = cause_d | rise_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= din_i;
      cause_q <= cause_d;
    end
  end

  assign combined = (cause_q & emask_i) | (din_i & lmask_i);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign irq_o[g] = |combined[g*GROUP +: GROUP];
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned GROUP   = 8,
  parameter int unsigned SYNC_ST = 2,
  localparam int unsigned N_GRP  = W / GROUP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rd_data_o,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o,
  output logic [W-1:0]      blink_en_o,
  output logic [W-1:0]      blink_sel_o,
  output logic [N_GRP-1:0]  irq_o
);
  logic [W-1:0] sync_q, din, cause_q, rise;
  logic [W-1:0] dir_q, pol_q, emask_q, lmask_q;
  logic         cause_wr;

  gpio_sync #(.W(W), .STAGES(SYNC_ST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_q)
  );

  assign din = sync_q ^ pol_q;

  gpio_regfile #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rd_data_o(rd_data_o),
    .din_i(din), .cause_i(cause_q), .cause_wr_o(cause_wr),
    .out_o(pin_o), .dir_o(dir_q), .blink_o(blink_en_o), .pol_o(pol_q),
    .emask_o(emask_q), .lmask_o(lmask_q), .bsel_o(blink_sel_o)
  );

  gpio_irq #(.W(W), .GROUP(GROUP)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(din),
    .clr_en_i(cause_wr), .clr_data_i(wdata_i),
    .emask_i(emask_q), .lmask_i(lmask_q),
    .cause_o(cause_q), .rise_o(rise), .irq_o(irq_o)
  );

  assign pin_oe_o = ~dir_q;
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned N_GRP = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      rd_data_o,
  input logic [W-1:0]      din_i,
  input logic [W-1:0]      cause_i,
  input logic [W-1:0]      rise_i,
  input logic [W-1:0]      emask_i,
  input logic [W-1:0]      lmask_i,
  input logic [N_GRP-1:0]  irq_o
);
  logic cause_wr;
  assign cause_wr = wr_en_i && (addr_i == OFF_CAUSE);

  a_r6_clear_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_wr |=> ((cause_i & ~$past(wdata_i) & ~$past(rise_i)) == '0));

  a_r7_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((cause_i & $past(rise_i)) == $past(rise_i)));

  a_r5_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_i & ~$past(cause_i) & ~$past(rise_i)) == '0));

  a_r10_quiet_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cause_i & emask_i) | (din_i & lmask_i)) == '0) |-> (irq_o == '0));

  a_r4_din_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_DIN) |-> (rd_data_o == din_i));

  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i > OFF_BSEL) |-> (rd_data_o == '0));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.W(W), .N_GRP(N_GRP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rd_data_o(rd_data_o),
  .din_i(din), .cause_i(cause_q), .rise_i(rise),
  .emask_i(emask_q), .lmask_i(lmask_q), .irq_o(irq_o)
);

// File: tb/gpio_bank_irq_bench.sv
`timescale 1ns/1ps
module gpio_bank_irq_bench;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [W-1:0] wdata = '0, pins = '0;
  logic [W-1:0] rd_data, pin_out, pin_oe, blink_en, blink_sel;
  logic [3:0] irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank_irq u_gpio_bank_irq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data),
    .pin_i(pins), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .blink_en_o(blink_en), .blink_sel_o(blink_sel), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [7:0] offs [7];
    offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h20};
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk("R1 oe", pin_oe, '1);
    chk("R1 pin_o", pin_out, '0);
    chk("R1 irq", {28'd0, irq}, '0);
    for (int a = 0; a <= 8'h20; a += 4) begin
      rd(a[7:0], v);
      chk("R1 reg", v, '0);
    end

    // R2 read-back of writable registers
    for (int i = 0; i < 7; i++) begin
      wr(offs[i], 32'h1234_5678 ^ (32'h1111_1111 * i));
      rd(offs[i], v);
      chk("R2 readback", v, 32'h1234_5678 ^ (32'h1111_1111 * i));
    end
    chk("R2 blink_en", blink_en, 32'h1234_5678 ^ 32'h2222_2222);
    chk("R2 blink_sel", blink_sel, 32'h1234_5678 ^ 32'h6666_6666);
    for (int i = 0; i < 7; i++) wr(offs[i], '0);
    wr(8'h14, '0);

    // R3 direction and output
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h00, 32'hA5A5_A5A5);
    chk("R3 oe", pin_oe, 32'hFFFF_0000);
    chk("R3 pin_o", pin_out, 32'hA5A5_A5A5);
    wr(8'h04, '1);
    chk("R3 all input", pin_oe, '0);

    // R4 data-in, polarity, latency, write ignored
    pins = 32'hC3C3_0F0F;
    cyc(3);
    rd(8'h10, v); chk("R4 din", v, 32'hC3C3_0F0F);
    wr(8'h0C, 32'hFFFF_0000);
    rd(8'h10, v); chk("R4 din pol", v, 32'h3C3C_0F0F);
    pins = 32'h0000_0000;
    cyc(1);
    rd(8'h10, v); chk("R4 after one edge", v, 32'h3C3C_0F0F);
    cyc(1);
    rd(8'h10, v); chk("R4 after two edges", v, 32'hFFFF_0000);
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, v); chk("R4 write ignored", v, 32'hFFFF_0000);
    wr(8'h0C, '0);
    cyc(2);
    wr(8'h14, '0);
    rd(8'h14, v); chk("R6 clear all", v, '0);

    // R5 R9 R10 sweep of every pin
    wr(8'h18, '1);
    for (int i = 0; i < W; i++) begin
      pins = 32'd1 << i;
      cyc(3);
      rd(8'h14, v); chk("R5 rise sets", v, 32'd1 << i);
      chk("R10 group", {28'd0, irq}, 32'd1 << (i / 8));
      pins = '0;
      cyc(3);
      rd(8'h14, v); chk("R5 fall no set", v, 32'd1 << i);
      wr(8'h14, '0);
      rd(8'h14, v); chk("R6 clear", v, '0);
      chk("R10 cleared", {28'd0, irq}, '0);
    end

    // R5 falling edge through polarity
    pins = 32'd1 << 5;
    cyc(3);
    wr(8'h0C, 32'd1 << 5);
    cyc(2);
    wr(8'h14, '0);
    pins = '0;
    cyc(3);
    rd(8'h14, v); chk("R5 falling via pol", v, 32'd1 << 5);
    wr(8'h0C, '0);
    cyc(2);
    wr(8'h14, '0);

    // R6 write ones keep
    pins = '1;
    cyc(3);
    rd(8'h14, v); chk("R6 all set", v, '1);
    wr(8'h14, 32'hF0F0_F0F0);
    rd(8'h14, v); chk("R6 ones keep", v, 32'hF0F0_F0F0);

    // R9 edge mask gating
    wr(8'h18, '0);
    chk("R9 masked irq", {28'd0, irq}, '0);
    rd(8'h14, v); chk("R9 cause kept", v, 32'hF0F0_F0F0);
    wr(8'h18, 32'h0000_1000);
    chk("R9 unmasked", {28'd0, irq}, 32'h2);
    wr(8'h18, '0);
    pins = '0;
    cyc(3);
    wr(8'h14, '0);

    // R8 level cause
    wr(8'h1C, 32'd1 << 12);
    pins = 32'd1 << 12;
    cyc(2);
    chk("R8 level asserted", {28'd0, irq}, 32'h2);
    cyc(10);
    wr(8'h14, '0);
    chk("R8 level persists", {28'd0, irq}, 32'h2);
    pins = 32'd1 << 20;
    cyc(2);
    chk("R8 level released", {28'd0, irq}, '0);
    wr(8'h1C, '0);
    pins = '0;
    cyc(3);
    wr(8'h14, '0);

    // R7 edge beats same-cycle clear
    pins = 32'd1 << 7;
    cyc(3);
    pins = 32'd1 << 3;
    cyc(2);
    wr(8'h14, '0);
    rd(8'h14, v); chk("R7 edge wins", v, 32'd1 << 3);

    // R11 unmapped
    rd(8'h24, v); chk("R11 0x24", v, '0);
    rd(8'h3C, v); chk("R11 0x3C", v, '0);
    rd(8'hFC, v); chk("R11 0xFC", v, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule